// File: doc/BRIEF.md
# General-Purpose Pin Bank Controller

This block manages a bank of general-purpose pins, 32 by default. Each pin has its own control word. The word selects whether the pin is driven as plain I/O or handed to one of three alternate functions. It also holds the drive style (push-pull or open-drain), the output enable, the pull resistor, the power state, the output value and the event detection mode. Reading a control word also returns the pin's synchronized input level.

Every pad input passes through a two-stage synchronizer. The synchronized level feeds a per-pin detector with five modes: rising edge, falling edge, either edge, low level and high level. Each pin's events go out on a vector toward an external interrupt collector. Edge events are one cycle long. Level events stay high for as long as the level matches.

A simple register bus reaches the per-pin words and two bank-wide words. One returns all synchronized pin levels together. The other supplies output values for pins that are set to take their value from it.

Top module: `gpio_bank`

## Requirements
- R1: After reset every control word and the bank output word read 0, and `pad_oe` and `irq_evt` are all 0.
- R2: A write to address i (i < NPINS) stores only the defined fields. A read of that address returns the stored fields and 0 in every undefined bit. Writing 0xFFFFFFFF reads back as 0x0001377F when the pin input is low. The field positions are: pull [1:0], power [3:2], detect mode [6:4], open-drain 8, output enable 9, output source 10, function select [13:12], output value 16, input level 24 (read-only).
- R3: Bit 24 of a control word, and bit i of the input word at address NPINS, show pad input i two clock edges after it changes.
- R4: With function select 0, push-pull and power on, `pad_oe` follows the output enable bit and `pad_out` follows bit 16.
- R5: When bit 10 is set, the driven value is bit i of the bank output word at address NPINS+1, not bit 16.
- R6: In open-drain mode with the output enable bit set, a driven value of 1 releases the pad (`pad_oe` 0) and a value of 0 drives it low (`pad_oe` 1, `pad_out` 0).
- R7: Function select k (1..3) drives `pad_out[i]` and `pad_oe[i]` from `alt_out[(k-1)*NPINS+i]` and `alt_oe[(k-1)*NPINS+i]`.
- R8: Pull field 01 asserts `pad_pu`, 10 asserts `pad_pd`, and 00 or 11 asserts neither.
- R9: Detect mode 001 (rising), 010 (falling) and 011 (either edge) raise `irq_evt[i]` for exactly one cycle, three edges after the matching input change. A change in the other direction raises nothing.
- R10: Detect mode 100 (low) and 101 (high) hold `irq_evt[i]` high every cycle while the synchronized level matches. The event begins three edges after the level arrives and ends three edges after it leaves.
- R11: Detect modes 000, 110 and 111 never raise an event.
- R12: Power field 10 forces `pad_oe[i]` low, asserts `pad_pwroff[i]` and suppresses events. An input change made while the pin is off does not produce an event once power returns.
- R13: Writes to the input word address have no effect on what that address reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | AW | Register address (pin words, then input word, then output word) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| pad_in | input | NPINS | Raw pad input levels |
| alt_out | input | 3*NPINS | Alternate function output values, function-major |
| alt_oe | input | 3*NPINS | Alternate function output enables, function-major |
| pad_out | output | NPINS | Pad output value |
| pad_oe | output | NPINS | Pad output enable |
| pad_pu | output | NPINS | Pull-up enable |
| pad_pd | output | NPINS | Pull-down enable |
| pad_pwroff | output | NPINS | Pad power-off control |
| irq_evt | output | NPINS | Per-pin detected event toward the collector |

## Verification
The bench counts events cycle by cycle around each input change. A detector with an extra or missing stage, or one that stretches a pulse, shows up as an event in the wrong cycle or an event of the wrong length. Level modes are held across several cycles and then released. This catches a detector that fires only once, or one that lets go too early. The power-off sequence changes the input while the pin is dark and then powers it back on. A detector whose history stopped updating while off would report a false edge at that point. The bench also aims writes at undefined bits, at the read-only level bit and at the input word, to show that stray bits are neither stored nor echoed.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  localparam int CW   = 32;
  localparam int NALT = 3;

  localparam int LVL_BIT = 24;

  localparam logic [1:0] PWR_OFF   = 2'b10;
  localparam logic [1:0] PULL_UP   = 2'b01;
  localparam logic [1:0] PULL_DOWN = 2'b10;

  localparam logic [2:0] DET_RISE = 3'd1;
  localparam logic [2:0] DET_FALL = 3'd2;
  localparam logic [2:0] DET_BOTH = 3'd3;
  localparam logic [2:0] DET_LOW  = 3'd4;
  localparam logic [2:0] DET_HIGH = 3'd5;

  typedef logic [CW-1:0] ctl_word_t;

  typedef struct packed {
    logic [1:0] fsel;
    logic       oval;
    logic       osrc;
    logic       oen;
    logic       odrain;
    logic [2:0] det;
    logic [1:0] pwr;
    logic [1:0] pull;
  } pin_cfg_t;

  function automatic pin_cfg_t cfg_from_word(ctl_word_t w);
    pin_cfg_t c;
    c.pull   = w[1:0];
    c.pwr    = w[3:2];
    c.det    = w[6:4];
    c.odrain = w[8];
    c.oen    = w[9];
    c.osrc   = w[10];
    c.fsel   = w[13:12];
    c.oval   = w[16];
    return c;
  endfunction

  function automatic ctl_word_t word_from_cfg(pin_cfg_t c, logic lvl);
    ctl_word_t w;
    w          = '0;
    w[1:0]     = c.pull;
    w[3:2]     = c.pwr;
    w[6:4]     = c.det;
    w[8]       = c.odrain;
    w[9]       = c.oen;
    w[10]      = c.osrc;
    w[13:12]   = c.fsel;
    w[16]      = c.oval;
    w[LVL_BIT] = lvl;
    return w;
  endfunction

endpackage

// File: rtl/gpio_rst_sync.sv
module gpio_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] stage_q;
  logic [1:0] stage_d;

  always_comb stage_d = {stage_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= '0;
    else        stage_q <= stage_d;
  end

  assign rst_n_sync = stage_q[1];
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int NPINS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pad_in,
  output logic [NPINS-1:0] lvl
);
  logic [NPINS-1:0] meta_q;
  logic [NPINS-1:0] lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      lvl_q  <= '0;
    end else begin
      meta_q <= pad_in;
      lvl_q  <= meta_q;
    end
  end

  assign lvl = lvl_q;
endmodule

// File: rtl/gpio_pin_detect.sv
module gpio_pin_detect
  import gpio_bank_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       lvl,
  input  logic [2:0] mode,
  input  logic       pwr_off,
  output logic       evt
);
  logic prev_q;
  logic evt_q;
  logic hit;
  logic evt_d;

  always_comb begin
    case (mode)
      DET_RISE: hit = lvl & ~prev_q;
      DET_FALL: hit = ~lvl & prev_q;
      DET_BOTH: hit = lvl ^ prev_q;
      DET_LOW:  hit = ~lvl;
      DET_HIGH: hit = lvl;
      default:  hit = 1'b0;
    endcase
    evt_d = hit & ~pwr_off;
  end

  // History keeps tracking while powered off so power-up sees no stale edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      evt_q  <= 1'b0;
    end else begin
      prev_q <= lvl;
      evt_q  <= evt_d;
    end
  end

  assign evt = evt_q;
endmodule

// File: rtl/gpio_pin_pad.sv
module gpio_pin_pad
  import gpio_bank_pkg::*;
(
  input  logic [1:0]      fsel,
  input  logic            oval,
  input  logic            osrc,
  input  logic            oen,
  input  logic            odrain,
  input  logic [1:0]      pwr,
  input  logic [1:0]      pull,
  input  logic            bank_bit,
  input  logic [NALT-1:0] alt_o,
  input  logic [NALT-1:0] alt_e,
  output logic            out,
  output logic            oe,
  output logic            pu,
  output logic            pd,
  output logic            off
);
  logic val;

  always_comb begin
    off = (pwr == PWR_OFF);
    val = osrc ? bank_bit : oval;
    if (odrain) begin
      out = 1'b0;
      oe  = oen & ~val;
    end else begin
      out = val;
      oe  = oen;
    end
    for (int k = 0; k < NALT; k++) begin
      if (fsel == 2'(k + 1)) begin
        out = alt_o[k];
        oe  = alt_e[k];
      end
    end
    if (off) oe = 1'b0;
    pu = (pull == PULL_UP);
    pd = (pull == PULL_DOWN);
  end
endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
  import gpio_bank_pkg::*;
#(
  parameter int NPINS = 32,
  parameter int AW    = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [AW-1:0]    addr,
  input  logic [CW-1:0]    wdata,
  input  logic [NPINS-1:0] lvl,
  output pin_cfg_t         cfg [NPINS],
  output logic [NPINS-1:0] bank_out,
  output logic [CW-1:0]    rdata
);
  localparam int IW = (NPINS > 1) ? $clog2(NPINS) : 1;
  localparam logic [AW-1:0] A_IN  = AW'(NPINS);
  localparam logic [AW-1:0] A_OUT = AW'(NPINS + 1);

  for (genvar i = 0; i < NPINS; i++) begin : g_word
    logic     sel;
    pin_cfg_t word_q;
    assign sel = we && (addr == AW'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   word_q <= '0;
      else if (sel) word_q <= cfg_from_word(wdata);
    end
    assign cfg[i] = word_q;
  end

  logic             out_sel;
  logic [NPINS-1:0] out_q;
  assign out_sel = we && (addr == A_OUT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       out_q <= '0;
    else if (out_sel) out_q <= wdata[NPINS-1:0];
  end
  assign bank_out = out_q;

  logic [IW-1:0] idx;
  assign idx = addr[IW-1:0];

  always_comb begin
    rdata = '0;
    if (int'(addr) < NPINS)  rdata = word_from_cfg(cfg[idx], lvl[idx]);
    else if (addr == A_IN)   rdata[NPINS-1:0] = lvl;
    else if (addr == A_OUT)  rdata[NPINS-1:0] = out_q;
  end
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter  int NPINS = 32,
  localparam int AW    = $clog2(NPINS) + 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_we,
  input  logic [AW-1:0]         bus_addr,
  input  logic [31:0]           bus_wdata,
  output logic [31:0]           bus_rdata,
  input  logic [NPINS-1:0]      pad_in,
  input  logic [3*NPINS-1:0]    alt_out,
  input  logic [3*NPINS-1:0]    alt_oe,
  output logic [NPINS-1:0]      pad_out,
  output logic [NPINS-1:0]      pad_oe,
  output logic [NPINS-1:0]      pad_pu,
  output logic [NPINS-1:0]      pad_pd,
  output logic [NPINS-1:0]      pad_pwroff,
  output logic [NPINS-1:0]      irq_evt
);
  logic             rst_n_s;
  logic [NPINS-1:0] lvl;
  logic [NPINS-1:0] bank_out;
  pin_cfg_t         cfg [NPINS];

  gpio_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s));

  gpio_in_sync #(.NPINS(NPINS)) u_sync (
    .clk(clk), .rst_n(rst_n_s), .pad_in(pad_in), .lvl(lvl)
  );

  gpio_bank_regs #(.NPINS(NPINS), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n_s), .we(bus_we), .addr(bus_addr),
    .wdata(bus_wdata), .lvl(lvl), .cfg(cfg), .bank_out(bank_out),
    .rdata(bus_rdata)
  );

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    logic [NALT-1:0] ao;
    logic [NALT-1:0] ae;
    for (genvar k = 0; k < NALT; k++) begin : g_alt
      assign ao[k] = alt_out[k*NPINS + i];
      assign ae[k] = alt_oe[k*NPINS + i];
    end

    gpio_pin_pad u_pad (
      .fsel(cfg[i].fsel), .oval(cfg[i].oval), .osrc(cfg[i].osrc),
      .oen(cfg[i].oen), .odrain(cfg[i].odrain), .pwr(cfg[i].pwr),
      .pull(cfg[i].pull), .bank_bit(bank_out[i]), .alt_o(ao), .alt_e(ae),
      .out(pad_out[i]), .oe(pad_oe[i]), .pu(pad_pu[i]), .pd(pad_pd[i]),
      .off(pad_pwroff[i])
    );

    gpio_pin_detect u_det (
      .clk(clk), .rst_n(rst_n_s), .lvl(lvl[i]), .mode(cfg[i].det),
      .pwr_off(pad_pwroff[i]), .evt(irq_evt[i])
    );
  end
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk
  import gpio_bank_pkg::*;
#(
  parameter int NPINS = 32
) (
  input logic             clk,
  input logic             rst_n,
  input pin_cfg_t         cfg [NPINS],
  input logic [NPINS-1:0] lvl,
  input logic [NPINS-1:0] pad_out,
  input logic [NPINS-1:0] pad_oe,
  input logic [NPINS-1:0] pad_pwroff,
  input logic [NPINS-1:0] irq_evt
);
  logic [NPINS-1:0] edge_m, high_m, quiet_m, od_m;

  always_comb begin
    for (int i = 0; i < NPINS; i++) begin
      edge_m[i]  = (cfg[i].det == DET_RISE) || (cfg[i].det == DET_FALL) ||
                   (cfg[i].det == DET_BOTH);
      high_m[i]  = (cfg[i].det == DET_HIGH);
      quiet_m[i] = (cfg[i].det == 3'd0) || (cfg[i].det == 3'd6) ||
                   (cfg[i].det == 3'd7);
      od_m[i]    = cfg[i].odrain && (cfg[i].fsel == 2'd0);
    end
  end

  a_r12_off_never_drives: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe & pad_pwroff) == '0);

  a_r12_off_no_event: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_evt & $past(pad_pwroff)) == '0);

  a_r9_edge_needs_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_evt & $past(edge_m) & ~($past(lvl) ^ $past(lvl, 2))) == '0);

  a_r10_high_needs_level: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_evt & $past(high_m) & ~$past(lvl)) == '0);

  a_r11_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_evt & $past(quiet_m)) == '0);

  a_r6_od_never_high: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe & pad_out & od_m) == '0);
endmodule

bind gpio_bank gpio_bank_chk #(.NPINS(NPINS)) u_chk (
  .clk(clk), .rst_n(rst_n_s), .cfg(cfg), .lvl(lvl), .pad_out(pad_out),
  .pad_oe(pad_oe), .pad_pwroff(pad_pwroff), .irq_evt(irq_evt)
);

// File: tb/gpio_bank_tb.sv
`timescale 1ns/1ps
module gpio_bank_tb;
  localparam int N  = 32;
  localparam int AW = $clog2(N) + 1;

  localparam logic [31:0] F_PU   = 32'h1;
  localparam logic [31:0] F_PD   = 32'h2;
  localparam logic [31:0] F_OFF  = 32'h8;
  localparam logic [31:0] F_OD   = 32'h100;
  localparam logic [31:0] F_OE   = 32'h200;
  localparam logic [31:0] F_OSRC = 32'h400;
  localparam logic [31:0] F_VAL  = 32'h10000;

  function automatic logic [31:0] det(int m);
    return 32'(m) << 4;
  endfunction

  function automatic logic [31:0] fs(int k);
    return 32'(k) << 12;
  endfunction

  logic clk = 1'b0;
  logic rst_n;
  logic bus_we;
  logic [AW-1:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic [N-1:0] pad_in;
  logic [3*N-1:0] alt_out, alt_oe;
  logic [N-1:0] pad_out, pad_oe, pad_pu, pad_pd, pad_pwroff, irq_evt;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  gpio_bank #(.NPINS(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .alt_out(alt_out), .alt_oe(alt_oe), .pad_out(pad_out), .pad_oe(pad_oe),
    .pad_pu(pad_pu), .pad_pd(pad_pd), .pad_pwroff(pad_pwroff),
    .irq_evt(irq_evt)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = AW'(a); bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_we = 1'b0;
    #1;
  endtask

  task automatic rd(int a, output logic [31:0] d);
    bus_addr = AW'(a);
    #1;
    d = bus_rdata;
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
    #1;
  endtask

  // Drive pin p to v, then watch five cycles; a pulse expected only in cycle 3.
  task automatic watch_edge(string req, int p, logic v, logic expect_evt);
    @(negedge clk);
    pad_in[p] = v;
    for (int k = 1; k <= 5; k++) begin
      @(posedge clk);
      @(negedge clk);
      #1;
      chk(req, 32'(irq_evt[p]), 32'(expect_evt && k == 3));
    end
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(0, d);      chk("R1 word0", d, 32'h0);
    rd(N - 1, d);  chk("R1 last word", d, 32'h0);
    rd(N + 1, d);  chk("R1 bank out word", d, 32'h0);
    chk("R1 pad_oe", pad_oe, 32'h0);
    chk("R1 irq_evt", irq_evt, 32'h0);
  endtask

  task automatic t_regs();
    logic [31:0] d;
    wr(5, 32'hFFFF_FFFF);
    rd(5, d); chk("R2 masked store", d, 32'h0001_377F);
    wr(5, 32'h0000_1234);
    rd(5, d); chk("R2 partial store", d, 32'h0000_1234 & 32'h0001_377F);
    wr(5, 32'h0);
    rd(5, d); chk("R2 cleared", d, 32'h0);
  endtask

  task automatic t_input();
    logic [31:0] d;
    @(negedge clk);
    pad_in[7] = 1'b1;
    @(posedge clk); @(negedge clk); #1;
    rd(7, d); chk("R3 one edge not yet", 32'(d[24]), 32'h0);
    @(posedge clk); @(negedge clk); #1;
    rd(7, d); chk("R3 level bit", 32'(d[24]), 32'h1);
    rd(N, d); chk("R3 input word", d, 32'h0000_0080);
    wr(N, 32'h0);
    rd(N, d); chk("R13 input word write ignored", d, 32'h0000_0080);
    @(negedge clk);
    pad_in[7] = 1'b0;
    settle();
  endtask

  task automatic t_pushpull();
    wr(3, F_OE | F_VAL);
    chk("R4 oe", 32'(pad_oe[3]), 32'h1);
    chk("R4 out high", 32'(pad_out[3]), 32'h1);
    wr(3, F_OE);
    chk("R4 out low", 32'(pad_out[3]), 32'h0);
    wr(3, F_VAL);
    chk("R4 oe off", 32'(pad_oe[3]), 32'h0);
  endtask

  task automatic t_osrc();
    wr(N + 1, 32'h0000_0008);
    wr(3, F_OE | F_OSRC);
    chk("R5 bank bit 1", 32'(pad_out[3]), 32'h1);
    wr(N + 1, 32'h0);
    chk("R5 bank bit 0", 32'(pad_out[3]), 32'h0);
    wr(3, F_OE | F_OSRC | F_VAL);
    chk("R5 own bit ignored", 32'(pad_out[3]), 32'h0);
    wr(3, 32'h0);
  endtask

  task automatic t_od();
    wr(6, F_OD | F_OE | F_VAL);
    chk("R6 release", 32'(pad_oe[6]), 32'h0);
    wr(6, F_OD | F_OE);
    chk("R6 drive oe", 32'(pad_oe[6]), 32'h1);
    chk("R6 drive low", 32'(pad_out[6]), 32'h0);
    wr(6, 32'h0);
  endtask

  task automatic t_mux();
    @(negedge clk);
    alt_out[N + 4] = 1'b1; alt_oe[N + 4] = 1'b1;
    alt_out[4] = 1'b0;     alt_oe[4] = 1'b1;
    wr(4, fs(2));
    chk("R7 fn2 out", 32'(pad_out[4]), 32'h1);
    chk("R7 fn2 oe", 32'(pad_oe[4]), 32'h1);
    wr(4, fs(1) | F_VAL | F_OE);
    chk("R7 fn1 out", 32'(pad_out[4]), 32'h0);
    wr(4, fs(3) | F_OE);
    chk("R7 fn3 oe", 32'(pad_oe[4]), 32'h0);
    wr(4, 32'h0);
  endtask

  task automatic t_pull();
    wr(8, F_PU);
    chk("R8 up", {30'h0, pad_pu[8], pad_pd[8]}, 32'h2);
    wr(8, F_PD);
    chk("R8 down", {30'h0, pad_pu[8], pad_pd[8]}, 32'h1);
    wr(8, F_PU | F_PD);
    chk("R8 none", {30'h0, pad_pu[8], pad_pd[8]}, 32'h0);
    wr(8, 32'h0);
  endtask

  task automatic t_edges();
    wr(9, det(1));
    watch_edge("R9 rise on rise", 9, 1'b1, 1'b1);
    watch_edge("R9 rise on fall", 9, 1'b0, 1'b0);
    wr(9, det(2));
    watch_edge("R9 fall on rise", 9, 1'b1, 1'b0);
    watch_edge("R9 fall on fall", 9, 1'b0, 1'b1);
    wr(9, det(3));
    watch_edge("R9 both rise", 9, 1'b1, 1'b1);
    watch_edge("R9 both fall", 9, 1'b0, 1'b1);
    wr(9, 32'h0);
  endtask

  task automatic t_levels();
    wr(10, det(5));
    settle();
    chk("R10 high idle", 32'(irq_evt[10]), 32'h0);
    @(negedge clk); pad_in[10] = 1'b1;
    for (int k = 1; k <= 6; k++) begin
      @(posedge clk); @(negedge clk); #1;
      chk("R10 high held", 32'(irq_evt[10]), 32'(k >= 3));
    end
    pad_in[10] = 1'b0;
    for (int k = 1; k <= 4; k++) begin
      @(posedge clk); @(negedge clk); #1;
      chk("R10 high release", 32'(irq_evt[10]), 32'(k < 3));
    end
    wr(10, det(4));
    @(posedge clk); @(negedge clk); #1;
    chk("R10 low active", 32'(irq_evt[10]), 32'h1);
    @(negedge clk); pad_in[10] = 1'b1;
    settle();
    chk("R10 low ends", 32'(irq_evt[10]), 32'h0);
    @(negedge clk); pad_in[10] = 1'b0;
    wr(10, 32'h0);
    settle();
  endtask

  task automatic t_disabled();
    wr(12, det(0));
    watch_edge("R11 mode0 rise", 12, 1'b1, 1'b0);
    wr(12, det(6));
    watch_edge("R11 mode6 fall", 12, 1'b0, 1'b0);
    wr(12, det(7));
    watch_edge("R11 mode7 rise", 12, 1'b1, 1'b0);
    @(negedge clk); pad_in[12] = 1'b0;
    wr(12, 32'h0);
    settle();
  endtask

  task automatic t_power();
    wr(11, F_OFF | F_OE | F_VAL | det(3));
    chk("R12 oe forced", 32'(pad_oe[11]), 32'h0);
    chk("R12 pwroff", 32'(pad_pwroff[11]), 32'h1);
    watch_edge("R12 no event off", 11, 1'b1, 1'b0);
    @(negedge clk); pad_in[11] = 1'b0;
    settle();
    wr(11, F_OE | F_VAL | det(3));
    chk("R12 pwr back", 32'(pad_pwroff[11]), 32'h0);
    chk("R12 oe back", 32'(pad_oe[11]), 32'h1);
    for (int k = 1; k <= 5; k++) begin
      @(posedge clk); @(negedge clk); #1;
      chk("R12 no false edge", 32'(irq_evt[11]), 32'h0);
    end
    watch_edge("R12 live after on", 11, 1'b1, 1'b1);
    wr(11, 32'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    pad_in = '0; alt_out = '0; alt_oe = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    t_reset();
    t_regs();
    t_input();
    t_pushpull();
    t_osrc();
    t_od();
    t_mux();
    t_pull();
    t_edges();
    t_levels();
    t_disabled();
    t_power();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule